// File: doc/BRIEF.md
# Auto-Increment Palette Lookup Unit

This block turns pixel codes into 24-bit colour. It keeps a 256-entry colour table, one border colour and three cursor colours. Software fills the table over a small register bus. It writes a start position to a pointer register, then streams colour words to a data port. Each word lands at the pointer, and the pointer then steps forward by one, wrapping at the end of the table. Reloading the whole table therefore takes one pointer write followed by 256 data writes.

On the pixel side a depth code selects 1, 2, 4, 8, 16 or 32 bits per pixel. At the four narrow depths the code indexes a single entry, and that entry supplies all three channels. At 16 bits each channel uses its own overlapping byte of the pixel as the index. At 32 bits each channel uses its own byte. A 2-bit cursor code, a border request and a blanking input are applied on top of the lookup, in a fixed priority order. The result is registered, so it appears one clock after the inputs.

Top module: `palette_lut`

## Requirements
- R1: After synchronous reset `rgb_out` is 0, the write pointer is 0, and the border and all three cursor colours are 0.
- R2: A write with `wr_sel`=0 loads the pointer from `wr_data[7:0]`. Bits 23:8 of that write are ignored.
- R3: A write with `wr_sel`=1 stores `wr_data` into the entry at the pointer and then increments the pointer.
- R4: The pointer wraps from 255 to 0. A data write at entry 255 is followed by a write to entry 0.
- R5: Depth codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bpp. The low 1, 2, 4 or 8 bits of `pix_code` are zero-extended to form a single index, and that one entry drives all three output channels.
- R6: Depth code 4 selects 16 bpp. Red is taken from the entry at `pix_code[7:0]`, green from the entry at `pix_code[11:4]`, and blue from the entry at `pix_code[15:8]`.
- R7: Depth code 6 selects 32 bpp. Red, green and blue are taken from the entries at `pix_code[7:0]`, `pix_code[15:8]` and `pix_code[23:16]`.
- R8: Depth codes 5 and 7 are reserved. With no cursor and no border request, they output black.
- R9: A nonzero `cur_code` n (1, 2 or 3) outputs cursor colour n (`wr_sel` 3, 4 or 5). This takes priority over both the border and the pixel.
- R10: When `border_sel` is high and no cursor is shown, the output is the border colour (`wr_sel`=2). The pixel is ignored.
- R11: When `blank` is high the output is 0, whatever the other inputs are.
- R12: The output reflects the inputs sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R13: Writes with `wr_sel` 6 or 7 change no state: the pointer, the table, the border and the cursor colours are untouched.
- R14: While all three cursor colours are zero the cursor is invisible. `cur_code` is then ignored, and the border or pixel shows instead.

Every colour word, and `rgb_out`, has red in bits 7:0, green in bits 15:8 and blue in bits 23:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write target: 0 pointer, 1 data, 2 border, 3-5 cursor colours |
| wr_data | input | 24 | Write data |
| pix_depth | input | 3 | Depth code |
| pix_code | input | 32 | Pixel code |
| cur_code | input | 2 | Cursor code, 0 transparent |
| border_sel | input | 1 | Show border colour |
| blank | input | 1 | Force black |
| rgb_out | output | 24 | Registered colour output |

## Verification
A pointer that has slipped or wrapped badly does no visible harm at the moment of the write. It shows only when the affected entry is looked up, two cycles after the data write at the earliest. For this reason the bench looks up specific entries right after pointer loads, after wrap-around and after ignored writes. A wrong slice choice at 16 or 32 bpp shows up in a single channel byte on the very next cycle. The bench therefore fills the table with entries whose three channel bytes all differ, so a wrong lane cannot hide. Priority faults among blank, cursor and border appear in the first cycle after the inputs change.

// File: rtl/clut_pkg.sv
package clut_pkg;
    parameter int IDX_W   = 8;
    parameter int CH_W    = 8;
    parameter int NCH     = 3;
    parameter int NCUR    = 3;
    parameter int PIX_W   = 32;
    parameter int SEL_W   = 3;
    parameter int DEP_W   = 3;
    localparam int COL_W   = NCH * CH_W;
    localparam int ENTRIES = 1 << IDX_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_PTR    = 3'd0,
        SEL_DATA   = 3'd1,
        SEL_BORDER = 3'd2,
        SEL_CUR1   = 3'd3,
        SEL_CUR2   = 3'd4,
        SEL_CUR3   = 3'd5
    } wsel_e;

    typedef enum logic [DEP_W-1:0] {
        DEP_1  = 3'd0,
        DEP_2  = 3'd1,
        DEP_4  = 3'd2,
        DEP_8  = 3'd3,
        DEP_16 = 3'd4,
        DEP_32 = 3'd6
    } depth_e;

    typedef struct packed {
        logic                       ok;
        logic [NCH-1:0][IDX_W-1:0]  lane;   // lane 0 red, 1 green, 2 blue
    } lut_idx_t;

    function automatic lut_idx_t map_pixel(input logic [DEP_W-1:0] depth,
                                           input logic [PIX_W-1:0] pix);
        lut_idx_t r;
        logic [IDX_W-1:0] one;
        r.ok = 1'b1;
        one  = '0;
        r.lane = '0;
        case (depth)
            DEP_1:  one = IDX_W'(pix[0]);
            DEP_2:  one = IDX_W'(pix[1:0]);
            DEP_4:  one = IDX_W'(pix[3:0]);
            DEP_8:  one = pix[7:0];
            default: one = '0;
        endcase
        case (depth)
            DEP_1, DEP_2, DEP_4, DEP_8: begin
                for (int c = 0; c < NCH; c++) r.lane[c] = one;
            end
            DEP_16: begin
                r.lane[0] = pix[7:0];
                r.lane[1] = pix[11:4];
                r.lane[2] = pix[15:8];
            end
            DEP_32: begin
                r.lane[0] = pix[7:0];
                r.lane[1] = pix[15:8];
                r.lane[2] = pix[23:16];
            end
            default: r.ok = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/clut_index.sv
module clut_index
    import clut_pkg::*;
(
    input  logic [DEP_W-1:0]            depth,
    input  logic [PIX_W-1:0]            pix,
    output logic [NCH-1:0][IDX_W-1:0]   lane,
    output logic                        lane_ok
);
    lut_idx_t sel;
    logic     unused_top_byte;

    always_comb sel = map_pixel(depth, pix);
    assign lane            = sel.lane;
    assign lane_ok         = sel.ok;
    assign unused_top_byte = ^pix[PIX_W-1:24];
endmodule

// File: rtl/clut_regfile.sv
module clut_regfile
    import clut_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [SEL_W-1:0]            wr_sel,
    input  logic [COL_W-1:0]            wr_data,
    input  logic [NCH-1:0][IDX_W-1:0]   rd_idx,
    output logic [NCH-1:0][COL_W-1:0]   rd_col,
    output logic [COL_W-1:0]            border_col,
    output logic [NCUR-1:0][COL_W-1:0]  cur_col
);
    logic [COL_W-1:0] pal_mem [ENTRIES];
    logic [IDX_W-1:0] wptr;
    logic             do_data;

    assign do_data = wr_en && (wr_sel == SEL_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr       <= '0;
            border_col <= '0;
            cur_col    <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_PTR:    wptr       <= wr_data[IDX_W-1:0];
                SEL_DATA:   wptr       <= wptr + 1'b1;
                SEL_BORDER: border_col <= wr_data;
                SEL_CUR1:   cur_col[0] <= wr_data;
                SEL_CUR2:   cur_col[1] <= wr_data;
                SEL_CUR3:   cur_col[2] <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && do_data) pal_mem[wptr] <= wr_data;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_rd
        assign rd_col[g] = pal_mem[rd_idx[g]];
    end

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_PTR) |=> wptr == $past(wr_data[IDX_W-1:0]));
    assert_ptr_step_R3: assert property (@(posedge clk) disable iff (rst)
        (do_data && wptr != '1) |=> wptr > $past(wptr));
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (do_data && wptr == '1) |=> wptr == '0);
    assert_ignored_sel_R13: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel > SEL_CUR3) |=> ($stable(wptr) && $stable(border_col) && $stable(cur_col)));
endmodule

// File: rtl/palette_lut.sv
module palette_lut
    import clut_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [COL_W-1:0]     wr_data,
    input  logic [DEP_W-1:0]     pix_depth,
    input  logic [PIX_W-1:0]     pix_code,
    input  logic [1:0]           cur_code,
    input  logic                 border_sel,
    input  logic                 blank,
    output logic [COL_W-1:0]     rgb_out
);
    logic [NCH-1:0][IDX_W-1:0]   lane;
    logic                        lane_ok;
    logic [NCH-1:0][COL_W-1:0]   rd_col;
    logic [COL_W-1:0]            border_col;
    logic [NCUR-1:0][COL_W-1:0]  cur_col;
    logic [COL_W-1:0]            pix_rgb;
    logic [COL_W-1:0]            nxt_rgb;
    logic                        cur_vis;

    clut_index u_index (
        .depth   (pix_depth),
        .pix     (pix_code),
        .lane    (lane),
        .lane_ok (lane_ok)
    );

    clut_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .rd_idx     (lane),
        .rd_col     (rd_col),
        .border_col (border_col),
        .cur_col    (cur_col)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        assign pix_rgb[ch*CH_W +: CH_W] = rd_col[ch][ch*CH_W +: CH_W];
    end

    assign cur_vis = |cur_col;

    always_comb begin
        if (blank)
            nxt_rgb = '0;
        else if (cur_code != 2'd0 && cur_vis)
            nxt_rgb = cur_col[cur_code - 2'd1];
        else if (border_sel)
            nxt_rgb = border_col;
        else if (!lane_ok)
            nxt_rgb = '0;
        else
            nxt_rgb = pix_rgb;
    end

    always_ff @(posedge clk) begin
        if (rst) rgb_out <= '0;
        else     rgb_out <= nxt_rgb;
    end

    assert_reset_black_R1: assert property (@(posedge clk)
        rst |=> rgb_out == '0);
    assert_blank_black_R11: assert property (@(posedge clk) disable iff (rst)
        blank |=> rgb_out == '0);
    assert_cursor_first_R9: assert property (@(posedge clk) disable iff (rst)
        (!blank && cur_code == 2'd1 && cur_vis) |=> rgb_out == $past(cur_col[0]));
    assert_border_R10: assert property (@(posedge clk) disable iff (rst)
        (!blank && (cur_code == 2'd0 || !cur_vis) && border_sel) |=> rgb_out == $past(border_col));
    assert_reserved_black_R8: assert property (@(posedge clk) disable iff (rst)
        (!blank && (cur_code == 2'd0 || !cur_vis) && !border_sel &&
         (pix_depth == 3'd5 || pix_depth == 3'd7)) |=> rgb_out == '0);
endmodule

// File: tb/palette_lut_bench.sv
`timescale 1ns/1ps
module palette_lut_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [23:0] wr_data = '0;
    logic [2:0]  pix_depth = '0;
    logic [31:0] pix_code = '0;
    logic [1:0]  cur_code = '0;
    logic        border_sel = 1'b0;
    logic        blank = 1'b0;
    logic [23:0] rgb_out;

    int checks = 0;
    int fails  = 0;
    logic [23:0] mpal [256];
    logic [7:0]  mptr = '0;
    logic [23:0] mborder = '0;
    logic [23:0] mcur [3];

    always #2 clk = ~clk;

    palette_lut u_palette_lut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pix_depth(pix_depth), .pix_code(pix_code), .cur_code(cur_code),
        .border_sel(border_sel), .blank(blank), .rgb_out(rgb_out)
    );

    function automatic logic [23:0] ent(input int i);
        return {8'(i * 7 + 3), 8'(i ^ 8'h5A), 8'(255 - i)};
    endfunction

    task automatic check(input logic [23:0] got, input logic [23:0] exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %06h expected %06h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [23:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (sel)
            3'd0: mptr = d[7:0];
            3'd1: begin mpal[mptr] = d; mptr = mptr + 8'd1; end
            3'd2: mborder = d;
            3'd3: mcur[0] = d;
            3'd4: mcur[1] = d;
            3'd5: mcur[2] = d;
            default: ;
        endcase
    endtask

    task automatic look(input logic [2:0] dep, input logic [31:0] pix,
                        input logic [1:0] cc, input logic bs, input logic bl);
        @(negedge clk);
        pix_depth = dep; pix_code = pix; cur_code = cc; border_sel = bs; blank = bl;
        @(negedge clk);
    endtask

    function automatic logic [23:0] model_pix(input logic [2:0] dep, input logic [31:0] pix);
        logic [7:0] ri, gi, bi;
        case (dep)
            3'd0: begin ri = {7'd0, pix[0]};   gi = ri; bi = ri; end
            3'd1: begin ri = {6'd0, pix[1:0]}; gi = ri; bi = ri; end
            3'd2: begin ri = {4'd0, pix[3:0]}; gi = ri; bi = ri; end
            3'd3: begin ri = pix[7:0];         gi = ri; bi = ri; end
            3'd4: begin ri = pix[7:0]; gi = pix[11:4];  bi = pix[15:8];  end
            3'd6: begin ri = pix[7:0]; gi = pix[15:8];  bi = pix[23:16]; end
            default: return 24'h0;
        endcase
        return {mpal[bi][23:16], mpal[gi][15:8], mpal[ri][7:0]};
    endfunction

    task automatic t_reset();
        check(rgb_out, 24'h0, "R1 reset output");
        look(3'd3, 32'h0, 2'd1, 1'b1, 1'b0);
        check(rgb_out, 24'h0, "R1 border and cursor cleared");
        wr(3'd1, 24'hC0FFEE);
        look(3'd3, 32'h0, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'hC0FFEE, "R1 pointer starts at 0");
    endtask

    task automatic t_load();
        wr(3'd0, 24'h0);
        for (int i = 0; i < 256; i++) wr(3'd1, ent(i));
        look(3'd3, 32'h0000_0080, 2'd0, 1'b0, 1'b0);
        check(rgb_out, mpal[8'h80], "R3 sequential load entry 0x80");
        look(3'd3, 32'h0000_00FF, 2'd0, 1'b0, 1'b0);
        check(rgb_out, mpal[8'hFF], "R3 sequential load entry 0xFF");
        wr(3'd1, 24'h123456);
        look(3'd3, 32'h0, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h123456, "R4 wrap after full load");
    endtask

    task automatic t_ptr();
        wr(3'd0, 24'hABCDF0);
        wr(3'd1, 24'h0A0B0C);
        wr(3'd1, 24'h0D0E0F);
        look(3'd3, 32'hF0, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h0A0B0C, "R2 pointer load low byte");
        look(3'd3, 32'hF1, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h0D0E0F, "R3 step after data write");
        wr(3'd0, 24'h0000FF);
        wr(3'd1, 24'h111111);
        wr(3'd1, 24'h222222);
        look(3'd3, 32'hFF, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h111111, "R4 entry 255");
        look(3'd3, 32'h00, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h222222, "R4 wrapped to entry 0");
        wr(3'd0, 24'h0);
        wr(3'd1, ent(0));
        wr(3'd0, 24'hFF);
        wr(3'd1, ent(255));
    endtask

    task automatic t_depths();
        look(3'd0, 32'hFFFF_FFF3, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd0, 32'hFFFF_FFF3), "R5 1bpp");
        look(3'd1, 32'hFFFF_FFF2, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd1, 32'hFFFF_FFF2), "R5 2bpp");
        look(3'd2, 32'hFFFF_FF9B, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd2, 32'hFFFF_FF9B), "R5 4bpp");
        look(3'd3, 32'hFFFF_FF9B, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd3, 32'hFFFF_FF9B), "R5 8bpp");
        look(3'd4, 32'hFFFF_ABCD, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd4, 32'hFFFF_ABCD), "R6 16bpp slices");
        look(3'd4, 32'h0000_1E2F, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd4, 32'h0000_1E2F), "R6 16bpp second pattern");
        look(3'd6, 32'hEE11_2233, 2'd0, 1'b0, 1'b0);
        check(rgb_out, model_pix(3'd6, 32'hEE11_2233), "R7 32bpp bytes");
        look(3'd5, 32'h0000_0010, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h0, "R8 reserved depth 5");
        look(3'd7, 32'h0000_0010, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h0, "R8 reserved depth 7");
    endtask

    task automatic t_latency();
        look(3'd3, 32'h10, 2'd0, 1'b0, 1'b0);
        check(rgb_out, mpal[8'h10], "R12 first value");
        @(negedge clk);
        pix_code = 32'h20;
        #1;
        check(rgb_out, mpal[8'h10], "R12 held before edge");
        @(negedge clk);
        check(rgb_out, mpal[8'h20], "R12 updated after one edge");
    endtask

    task automatic t_overlay();
        look(3'd3, 32'h33, 2'd2, 1'b1, 1'b0);
        check(rgb_out, 24'h0, "R14 invisible cursor, zero border");
        wr(3'd2, 24'h445566);
        look(3'd3, 32'h33, 2'd3, 1'b0, 1'b0);
        check(rgb_out, mpal[8'h33], "R14 invisible cursor shows pixel");
        look(3'd3, 32'h33, 2'd0, 1'b1, 1'b0);
        check(rgb_out, 24'h445566, "R10 border over pixel");
        wr(3'd3, 24'hA1A2A3);
        wr(3'd4, 24'hB1B2B3);
        wr(3'd5, 24'hC1C2C3);
        for (int c = 1; c <= 3; c++) begin
            look(3'd3, 32'h33, 2'(c), 1'b1, 1'b0);
            check(rgb_out, mcur[c-1], "R9 cursor over border");
        end
        look(3'd3, 32'h33, 2'd0, 1'b1, 1'b0);
        check(rgb_out, 24'h445566, "R9 code 0 transparent");
        look(3'd3, 32'h33, 2'd2, 1'b1, 1'b1);
        check(rgb_out, 24'h0, "R11 blank over cursor");
        look(3'd4, 32'hABCD, 2'd0, 1'b0, 1'b1);
        check(rgb_out, 24'h0, "R11 blank over pixel");
        wr(3'd3, 24'h0);
        wr(3'd4, 24'h0);
        wr(3'd5, 24'h0);
        look(3'd3, 32'h33, 2'd1, 1'b0, 1'b0);
        check(rgb_out, mpal[8'h33], "R14 cursor cleared again");
    endtask

    task automatic t_ignored();
        wr(3'd0, 24'h40);
        wr(3'd6, 24'hFFFFFF);
        wr(3'd7, 24'h000007);
        wr(3'd1, 24'h5A5A01);
        look(3'd3, 32'h40, 2'd0, 1'b0, 1'b0);
        check(rgb_out, 24'h5A5A01, "R13 pointer untouched");
        look(3'd3, 32'h07, 2'd0, 1'b0, 1'b0);
        check(rgb_out, mpal[8'h07], "R13 table untouched");
        look(3'd3, 32'h07, 2'd0, 1'b1, 1'b0);
        check(rgb_out, mborder, "R13 border untouched");
        look(3'd3, 32'h07, 2'd2, 1'b0, 1'b0);
        check(rgb_out, mpal[8'h07], "R13 cursor colours untouched");
    endtask

    initial begin
        mcur[0] = '0; mcur[1] = '0; mcur[2] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_ptr();
        t_depths();
        t_latency();
        t_overlay();
        t_ignored();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule